// File: doc/BRIEF.md
# Privileged Special-Register Access Unit

This block serves the move-to and move-from special-register operations of a small 32-bit processor core. Each request carries a 16-bit register number, built as a group number in bits 15:11 and an index within that group in bits 10:0. It also carries write data and the value that the destination general register held before the operation. A write strobe, a read strobe, or both may be raised in one cycle. The unit answers one clock later. It returns the read value on `rd_data`, or it returns a one-cycle `exc_illegal` pulse when a user-mode request targets a privileged register.

The unit stores the following state:
- the exception vector base, exception return PC, faulting address and saved-status registers
- the status register, whose bit 0 is the supervisor flag
- the floating-point control/status word
- a 64-bit accumulator, reached as two 32-bit halves
- a power-management register
- 16 banks of 32 shadow general registers
- way-0 match and translate entries for both the data TLB and the instruction TLB

The core's current PC arrives on `core_pc`. A redirect back into the pipeline is reported through `pc_load`, `pc_value` and `dslot_clr`. A request for a low-power state raises the sticky `halted` output.

Top module: `spr_access_unit`

## Requirements
- R1: The register number is the group times 2048 plus the index. Group 0 holds the system registers and shadow registers, group 1 the data TLB, group 2 the instruction TLB, group 5 the accumulator and group 8 power management.
- R2: In supervisor mode, the registers at group 0 index 11 (vector base), 32 (exception PC), 48 (faulting address) and 64 (saved status) return on a read the last value written. Index 128 reads as the CORE_ID parameter and index 129 as CORE_COUNT. Writes to indices 128 and 129 change nothing.
- R3: Group 0 index 20 (floating-point control/status) can be read and written in both user and supervisor mode, and it never raises an exception. Its value is also driven on `fpcsr_out`.
- R4: When bit 0 of the status register is 0 (user mode), any other request raises `exc_illegal` for exactly the cycle after the request. Such a request changes no register, causes no redirect and no halt. If it was a read, `rd_data` returns `dest_old`.
- R5: Group 0 index 17 is the status register and is driven on `status`. Writing it with bit 0 clear puts the unit in user mode.
- R6: Group 0 indices 1024 to 1535 address the shadow registers. Offset = index − 1024, bank = offset / 32, register = offset % 32. Each location holds its own value.
- R7: Group 5 index 1 is bits 31:0 of the accumulator and index 2 is bits 63:32. A write to one half leaves the other half unchanged.
- R8: In groups 1 and 2, indices 512+s are the way-0 match entries and indices 640+s are the way-0 translate entries, for s from 0 to TLB_SETS−1. The data and instruction tables are separate storage.
- R9: In groups 1 and 2, indices 768 to 1535 (ways 1 to 3) accept writes and ignore them. A read of any address that maps to no register returns `dest_old`.
- R10: Reset clears every register to zero, except that `status` resets to 1. After reset, `rd_data`, `exc_illegal`, `pc_load`, `dslot_clr` and `halted` are 0.
- R11: A write to group 0 index 16 (next PC) raises `pc_load` and `dslot_clr` one cycle later, with `pc_value` equal to the written value, but only if that value differs from `core_pc`. A read of index 16 returns `core_pc`.
- R12: A write to group 8 index 0 stores the value. If bit 4 (doze) or bit 5 (sleep) is set, one cycle later the unit raises `pc_load` with `pc_value` = `core_pc` + 4, leaves `dslot_clr` low, and sets `halted`, which stays high until reset.
- R13: Read results appear on `rd_data` the cycle after the request and hold until the next read. When a read and a write target the same register in one cycle, the read returns the value held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_wr | input | 1 | Move-to request strobe |
| req_rd | input | 1 | Move-from request strobe |
| req_addr | input | 16 | Register number {group, index} |
| req_wdata | input | 32 | Write data |
| dest_old | input | 32 | Prior value of the destination register |
| core_pc | input | 32 | Current PC of the core |
| rd_data | output | 32 | Read result |
| exc_illegal | output | 1 | Illegal-instruction pulse |
| pc_load | output | 1 | PC redirect strobe |
| pc_value | output | 32 | Redirect target |
| dslot_clr | output | 1 | Clear the delay-slot flag |
| halted | output | 1 | Low-power halt flag |
| status | output | 32 | Status register |
| fpcsr_out | output | 32 | Floating-point control/status |

## Verification
A read and a write can fall in the same cycle. When both target one register, the read must capture the value held before the write. When they sit on different halves of the accumulator, the read must not see the write. The bench raises both strobes together on the vector base register, on the accumulator and on a shadow location. A reference model reads its state before it applies the write, and the bench compares the model against `rd_data` in the following cycle and again after a later plain read. A second case is an illegal user-mode write to the power-management or next-PC register: the same cycle must show the exception but no redirect, and the bench checks both outputs together.

// File: rtl/spr_pkg.sv
package spr_pkg;

    localparam int SPR_GRP_SHIFT   = 11;
    localparam int GRP_SYS         = 0;
    localparam int GRP_DMMU        = 1;
    localparam int GRP_IMMU        = 2;
    localparam int GRP_MAC         = 5;
    localparam int GRP_PM          = 8;

    localparam int IX_VBASE        = 11;
    localparam int IX_NEXTPC       = 16;
    localparam int IX_STATUS       = 17;
    localparam int IX_FPCSR        = 20;
    localparam int IX_EXC_PC       = 32;
    localparam int IX_FAULT_ADR    = 48;
    localparam int IX_SAVED_ST     = 64;
    localparam int IX_CORE_ID      = 128;
    localparam int IX_CORE_CNT     = 129;
    localparam int IX_SHADOW_BASE  = 1024;
    localparam int IX_MAC_LO       = 1;
    localparam int IX_MAC_HI       = 2;
    localparam int IX_PM           = 0;

    localparam int TLB_MATCH_BASE  = 512;
    localparam int TLB_XLATE_BASE  = 640;
    localparam int TLB_OTHER_BASE  = 768;
    localparam int TLB_OTHER_END   = 1536;

    localparam int GPRS_PER_BANK   = 32;
    localparam int SUP_BIT         = 0;
    localparam int PM_DOZE_BIT     = 4;
    localparam int PM_SLEEP_BIT    = 5;

    typedef enum logic [4:0] {
        K_NONE, K_FPCSR, K_VBASE, K_NEXTPC, K_STATUS, K_EXC_PC, K_FAULT_ADR,
        K_SAVED_ST, K_CORE_ID, K_CORE_CNT, K_SHADOW, K_DTLB, K_ITLB,
        K_TLB_IGN, K_MAC_LO, K_MAC_HI, K_PM
    } spr_kind_e;

    typedef enum logic [1:0] {
        SRC_REG, SRC_SHADOW, SRC_DTLB, SRC_ITLB
    } rd_src_e;

    typedef struct packed {
        spr_kind_e   kind;
        logic [10:0] idx;
    } spr_dec_t;

    typedef struct packed {
        logic [31:0] vbase;
        logic [31:0] exc_pc;
        logic [31:0] fault_adr;
        logic [31:0] saved_st;
        logic [31:0] status;
        logic [31:0] fpcsr;
        logic [31:0] pm;
        logic [63:0] mac;
    } spr_state_t;

    function automatic logic [15:0] spr_addr(input int grp, input int ix);
        return 16'((grp << SPR_GRP_SHIFT) + ix);
    endfunction

endpackage

// File: rtl/spr_decode.sv
module spr_decode
    import spr_pkg::*;
#(
    parameter int TLB_SETS     = 128,
    parameter int SHADOW_WORDS = 512
) (
    input  logic [15:0] addr_i,
    output spr_dec_t    dec_o
);

    int grp;
    int ix;

    always_comb begin
        grp = int'(addr_i[15:11]);
        ix  = int'(addr_i[10:0]);
        dec_o.kind = K_NONE;
        dec_o.idx  = '0;
        if (grp == GRP_SYS) begin
            case (ix)
                IX_FPCSR:     dec_o.kind = K_FPCSR;
                IX_VBASE:     dec_o.kind = K_VBASE;
                IX_NEXTPC:    dec_o.kind = K_NEXTPC;
                IX_STATUS:    dec_o.kind = K_STATUS;
                IX_EXC_PC:    dec_o.kind = K_EXC_PC;
                IX_FAULT_ADR: dec_o.kind = K_FAULT_ADR;
                IX_SAVED_ST:  dec_o.kind = K_SAVED_ST;
                IX_CORE_ID:   dec_o.kind = K_CORE_ID;
                IX_CORE_CNT:  dec_o.kind = K_CORE_CNT;
                default:      dec_o.kind = K_NONE;
            endcase
            if (ix >= IX_SHADOW_BASE && ix < IX_SHADOW_BASE + SHADOW_WORDS) begin
                dec_o.kind = K_SHADOW;
                dec_o.idx  = 11'(ix - IX_SHADOW_BASE);
            end
        end else if (grp == GRP_DMMU || grp == GRP_IMMU) begin
            if (ix >= TLB_MATCH_BASE && ix < TLB_MATCH_BASE + TLB_SETS) begin
                dec_o.kind = (grp == GRP_DMMU) ? K_DTLB : K_ITLB;
                dec_o.idx  = 11'(ix - TLB_MATCH_BASE);
            end else if (ix >= TLB_XLATE_BASE && ix < TLB_XLATE_BASE + TLB_SETS) begin
                dec_o.kind = (grp == GRP_DMMU) ? K_DTLB : K_ITLB;
                dec_o.idx  = 11'(TLB_SETS + ix - TLB_XLATE_BASE);
            end else if (ix >= TLB_OTHER_BASE && ix < TLB_OTHER_END) begin
                dec_o.kind = K_TLB_IGN;
            end
        end else if (grp == GRP_MAC) begin
            if (ix == IX_MAC_LO) dec_o.kind = K_MAC_LO;
            if (ix == IX_MAC_HI) dec_o.kind = K_MAC_HI;
        end else if (grp == GRP_PM) begin
            if (ix == IX_PM) dec_o.kind = K_PM;
        end
    end

endmodule

// File: rtl/spr_ram.sv
module spr_ram #(
    parameter int DEPTH = 512,
    parameter int WIDTH = 32,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic             re,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);

    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            rdata <= '0;
        end else begin
            if (re) rdata <= mem[raddr];
            if (we) mem[waddr] <= wdata;
        end
    end

endmodule

// File: rtl/spr_access_unit.sv
module spr_access_unit
    import spr_pkg::*;
#(
    parameter int TLB_SETS     = 128,
    parameter int SHADOW_BANKS = 16,
    parameter int CORE_ID      = 0,
    parameter int CORE_COUNT   = 1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_wr,
    input  logic        req_rd,
    input  logic [15:0] req_addr,
    input  logic [31:0] req_wdata,
    input  logic [31:0] dest_old,
    input  logic [31:0] core_pc,
    output logic [31:0] rd_data,
    output logic        exc_illegal,
    output logic        pc_load,
    output logic [31:0] pc_value,
    output logic        dslot_clr,
    output logic        halted,
    output logic [31:0] status,
    output logic [31:0] fpcsr_out
);

    localparam int SH_WORDS  = SHADOW_BANKS * GPRS_PER_BANK;
    localparam int SH_AW     = $clog2(SH_WORDS);
    localparam int TLB_WORDS = 2 * TLB_SETS;
    localparam int TLB_AW    = $clog2(TLB_WORDS);

    spr_dec_t   dec;
    spr_state_t st_q, st_d;
    logic       legal, wr_ok, rd_ok, npc_redirect, pm_halt;
    logic [31:0] rd_scalar;
    rd_src_e    src_d, src_q;
    logic [31:0] scalar_q;
    logic [31:0] sh_rdata;
    logic [31:0] tlb_rdata [2];

    spr_decode #(.TLB_SETS(TLB_SETS), .SHADOW_WORDS(SH_WORDS)) u_dec (
        .addr_i (req_addr),
        .dec_o  (dec)
    );

    // privilege gate: only the FP control word escapes it
    assign legal = st_q.status[SUP_BIT] || (dec.kind == K_FPCSR);
    assign wr_ok = req_wr && legal;
    assign rd_ok = req_rd && legal;

    spr_ram #(.DEPTH(SH_WORDS), .WIDTH(32)) u_shadow (
        .clk   (clk),
        .rst   (rst),
        .we    (wr_ok && dec.kind == K_SHADOW),
        .waddr (SH_AW'(dec.idx)),
        .wdata (req_wdata),
        .re    (rd_ok && dec.kind == K_SHADOW),
        .raddr (SH_AW'(dec.idx)),
        .rdata (sh_rdata)
    );

    for (genvar s = 0; s < 2; s++) begin : g_tlb
        localparam spr_kind_e MY_KIND = (s == 0) ? K_DTLB : K_ITLB;
        spr_ram #(.DEPTH(TLB_WORDS), .WIDTH(32)) u_way0 (
            .clk   (clk),
            .rst   (rst),
            .we    (wr_ok && dec.kind == MY_KIND),
            .waddr (TLB_AW'(dec.idx)),
            .wdata (req_wdata),
            .re    (rd_ok && dec.kind == MY_KIND),
            .raddr (TLB_AW'(dec.idx)),
            .rdata (tlb_rdata[s])
        );
    end

    // scalar register updates
    always_comb begin
        st_d = st_q;
        if (wr_ok) begin
            case (dec.kind)
                K_FPCSR:     st_d.fpcsr     = req_wdata;
                K_VBASE:     st_d.vbase     = req_wdata;
                K_STATUS:    st_d.status    = req_wdata;
                K_EXC_PC:    st_d.exc_pc    = req_wdata;
                K_FAULT_ADR: st_d.fault_adr = req_wdata;
                K_SAVED_ST:  st_d.saved_st  = req_wdata;
                K_MAC_LO:    st_d.mac[31:0]  = req_wdata;
                K_MAC_HI:    st_d.mac[63:32] = req_wdata;
                K_PM:        st_d.pm        = req_wdata;
                default:     st_d = st_q;
            endcase
        end
    end

    // scalar read mux and read-source selection
    always_comb begin
        rd_scalar = dest_old;
        src_d     = SRC_REG;
        case (dec.kind)
            K_FPCSR:     rd_scalar = st_q.fpcsr;
            K_VBASE:     rd_scalar = st_q.vbase;
            K_NEXTPC:    rd_scalar = core_pc;
            K_STATUS:    rd_scalar = st_q.status;
            K_EXC_PC:    rd_scalar = st_q.exc_pc;
            K_FAULT_ADR: rd_scalar = st_q.fault_adr;
            K_SAVED_ST:  rd_scalar = st_q.saved_st;
            K_CORE_ID:   rd_scalar = 32'(CORE_ID);
            K_CORE_CNT:  rd_scalar = 32'(CORE_COUNT);
            K_MAC_LO:    rd_scalar = st_q.mac[31:0];
            K_MAC_HI:    rd_scalar = st_q.mac[63:32];
            K_PM:        rd_scalar = st_q.pm;
            K_SHADOW:    src_d     = SRC_SHADOW;
            K_DTLB:      src_d     = SRC_DTLB;
            K_ITLB:      src_d     = SRC_ITLB;
            default:     rd_scalar = dest_old;
        endcase
    end

    assign npc_redirect = wr_ok && dec.kind == K_NEXTPC && req_wdata != core_pc;
    assign pm_halt      = wr_ok && dec.kind == K_PM &&
                          (req_wdata[PM_DOZE_BIT] || req_wdata[PM_SLEEP_BIT]);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q        <= '0;
            st_q.status <= 32'(1 << SUP_BIT);
            src_q       <= SRC_REG;
            scalar_q    <= '0;
            exc_illegal <= 1'b0;
            pc_load     <= 1'b0;
            pc_value    <= '0;
            dslot_clr   <= 1'b0;
            halted      <= 1'b0;
        end else begin
            st_q        <= st_d;
            exc_illegal <= (req_wr || req_rd) && !legal;
            if (req_rd) begin
                src_q    <= rd_ok ? src_d : SRC_REG;
                scalar_q <= rd_ok ? rd_scalar : dest_old;
            end
            pc_load   <= npc_redirect || pm_halt;
            dslot_clr <= npc_redirect;
            if (npc_redirect) pc_value <= req_wdata;
            if (pm_halt)      pc_value <= core_pc + 32'd4;
            if (pm_halt)      halted   <= 1'b1;
        end
    end

    always_comb begin
        case (src_q)
            SRC_SHADOW: rd_data = sh_rdata;
            SRC_DTLB:   rd_data = tlb_rdata[0];
            SRC_ITLB:   rd_data = tlb_rdata[1];
            default:    rd_data = scalar_q;
        endcase
    end

    assign status    = st_q.status;
    assign fpcsr_out = st_q.fpcsr;

endmodule

// File: rtl/spr_access_chk.sv
module spr_access_chk
    import spr_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        req_wr,
    input logic        req_rd,
    input logic [15:0] req_addr,
    input logic [31:0] req_wdata,
    input logic [31:0] dest_old,
    input logic [31:0] core_pc,
    input logic [31:0] rd_data,
    input logic        exc_illegal,
    input logic        pc_load,
    input logic [31:0] pc_value,
    input logic        dslot_clr,
    input logic        halted,
    input logic [31:0] status
);

    logic user_priv_req;
    assign user_priv_req = !status[SUP_BIT] && req_addr != spr_addr(GRP_SYS, IX_FPCSR);

    AST_ILL_CAUSE: assert property (@(posedge clk) disable iff (rst)
        exc_illegal |-> $past(req_wr || req_rd) && !$past(status[SUP_BIT]) &&
                        $past(req_addr) != spr_addr(GRP_SYS, IX_FPCSR)); // R4

    AST_ILL_NO_EFFECT: assert property (@(posedge clk) disable iff (rst)
        (req_wr && user_priv_req) |=> !pc_load && $stable(status) && exc_illegal); // R4

    AST_ILL_RDATA: assert property (@(posedge clk) disable iff (rst)
        (req_rd && user_priv_req) |=> rd_data == $past(dest_old)); // R4

    AST_RESET_SUP: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> status == 32'd1 && !halted && !pc_load); // R10

    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (rst)
        halted |=> halted); // R12

    AST_HALT_PC: assert property (@(posedge clk) disable iff (rst)
        $rose(halted) |-> pc_load && !dslot_clr && pc_value == $past(core_pc) + 32'd4); // R12

    AST_NPC_SAME: assert property (@(posedge clk) disable iff (rst)
        (status[SUP_BIT] && req_wr && req_addr == spr_addr(GRP_SYS, IX_NEXTPC) &&
         req_wdata == core_pc) |=> !pc_load); // R11

    AST_DSLOT_WITH_LOAD: assert property (@(posedge clk) disable iff (rst)
        dslot_clr |-> pc_load); // R11

endmodule

bind spr_access_unit spr_access_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .req_wr      (req_wr),
    .req_rd      (req_rd),
    .req_addr    (req_addr),
    .req_wdata   (req_wdata),
    .dest_old    (dest_old),
    .core_pc     (core_pc),
    .rd_data     (rd_data),
    .exc_illegal (exc_illegal),
    .pc_load     (pc_load),
    .pc_value    (pc_value),
    .dslot_clr   (dslot_clr),
    .halted      (halted),
    .status      (status)
);

// File: tb/tb_spr_access_unit.sv
module tb_spr_access_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_wr = 1'b0, req_rd = 1'b0;
    logic [15:0] req_addr = '0;
    logic [31:0] req_wdata = '0, dest_old = '0, core_pc = 32'h0000_2000;
    logic [31:0] rd_data, pc_value, status, fpcsr_out;
    logic        exc_illegal, pc_load, dslot_clr, halted;

    always #10 clk = ~clk;   // 50 MHz

    spr_access_unit dut (
        .clk(clk), .rst(rst), .req_wr(req_wr), .req_rd(req_rd),
        .req_addr(req_addr), .req_wdata(req_wdata), .dest_old(dest_old),
        .core_pc(core_pc), .rd_data(rd_data), .exc_illegal(exc_illegal),
        .pc_load(pc_load), .pc_value(pc_value), .dslot_clr(dslot_clr),
        .halted(halted), .status(status), .fpcsr_out(fpcsr_out)
    );

    int checks = 0, errors = 0;
    bit done = 0;

    // reference model state
    logic [31:0] m_reg [string];
    logic [31:0] m_mem [int];
    logic [63:0] m_mac;
    logic [31:0] e_rd, e_pcval;
    bit          e_exc, e_load, e_dslot, e_halt;

    function automatic logic [15:0] A(int g, int i);
        return 16'(g * 2048 + i);
    endfunction

    function automatic logic [31:0] mget(int key);
        return m_mem.exists(key) ? m_mem[key] : 32'h0;
    endfunction

    function automatic string rname(logic [15:0] a);
        case (a)
            16'd11:  return "vb";
            16'd20:  return "fp";
            16'd17:  return "st";
            16'd32:  return "epc";
            16'd48:  return "fa";
            16'd64:  return "ss";
            16'h4000: return "pm";
            default: return "";
        endcase
    endfunction

    // memory key, or -1 for no storage
    function automatic int mkey(logic [15:0] a);
        int g = int'(a >> 11);
        int i = int'(a & 16'h7ff);
        if (g == 0 && i >= 1024 && i < 1536) return i;
        if ((g == 1 || g == 2) && i >= 512 && i < 768) return g * 10000 + i;
        return -1;
    endfunction

    function automatic logic [31:0] mread(logic [15:0] a, logic [31:0] old);
        string n = rname(a);
        if (n != "") return m_reg[n];
        if (a == A(0, 16)) return core_pc;
        if (a == A(0, 128)) return 32'd0;
        if (a == A(0, 129)) return 32'd1;
        if (a == A(5, 1)) return m_mac[31:0];
        if (a == A(5, 2)) return m_mac[63:32];
        if (mkey(a) >= 0) return mget(mkey(a));
        return old;
    endfunction

    task automatic model_reset();
        m_reg.delete(); m_mem.delete();
        m_reg["vb"] = 0; m_reg["fp"] = 0; m_reg["st"] = 1; m_reg["epc"] = 0;
        m_reg["fa"] = 0; m_reg["ss"] = 0; m_reg["pm"] = 0;
        m_mac = 0; e_rd = 0; e_pcval = 0;
        e_exc = 0; e_load = 0; e_dslot = 0; e_halt = 0;
    endtask

    task automatic model_step();
        bit legal = m_reg["st"][0] || req_addr == A(0, 20);
        string n = rname(req_addr);
        e_exc = (req_wr || req_rd) && !legal;
        e_load = 0; e_dslot = 0;
        if (req_rd) e_rd = legal ? mread(req_addr, dest_old) : dest_old;   // R13 read first
        if (req_wr && legal) begin
            if (n != "") m_reg[n] = req_wdata;
            else if (req_addr == A(5, 1)) m_mac[31:0] = req_wdata;
            else if (req_addr == A(5, 2)) m_mac[63:32] = req_wdata;
            else if (mkey(req_addr) >= 0) m_mem[mkey(req_addr)] = req_wdata;
            if (req_addr == A(0, 16) && req_wdata != core_pc) begin
                e_load = 1; e_dslot = 1; e_pcval = req_wdata;
            end
            if (req_addr == A(8, 0) && (req_wdata[4] || req_wdata[5])) begin
                e_load = 1; e_pcval = core_pc + 4; e_halt = 1;
            end
        end
    endtask

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic compare(string tag);
        chk(tag, "rd_data", rd_data, e_rd);
        chk(tag, "exc_illegal", 32'(exc_illegal), 32'(e_exc));
        chk(tag, "pc_load", 32'(pc_load), 32'(e_load));
        chk(tag, "dslot_clr", 32'(dslot_clr), 32'(e_dslot));
        chk(tag, "halted", 32'(halted), 32'(e_halt));
        chk(tag, "status", status, m_reg["st"]);
        chk(tag, "fpcsr_out", fpcsr_out, m_reg["fp"]);
        if (e_load) chk(tag, "pc_value", pc_value, e_pcval);
    endtask

    // one request cycle; compared at the following falling edge
    task automatic op(bit w, bit r, logic [15:0] a, logic [31:0] wd, logic [31:0] old, string tag);
        req_wr = w; req_rd = r; req_addr = a; req_wdata = wd; dest_old = old;
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare(tag);
        req_wr = 0; req_rd = 0;
    endtask

    task automatic wr(logic [15:0] a, logic [31:0] d, string tag); op(1, 0, a, d, 32'h0, tag); endtask
    task automatic rd(logic [15:0] a, logic [31:0] old, string tag); op(0, 1, a, 32'h0, old, tag); endtask

    task automatic do_reset();
        rst = 1; req_wr = 0; req_rd = 0;
        repeat (2) @(posedge clk);
        model_reset();
        @(negedge clk);
        rst = 0;
        compare("R10");   // R10 reset state
    endtask

    initial begin
        @(negedge clk);
        do_reset();

        // R1 R2 system registers in supervisor mode
        wr(A(0, 11), 32'h1000_0100, "R2"); rd(A(0, 11), 32'h0, "R2");
        wr(A(0, 32), 32'h0000_3A40, "R2"); wr(A(0, 48), 32'hDEAD_0008, "R2");
        wr(A(0, 64), 32'h0000_8001, "R2");
        rd(A(0, 32), 32'h0, "R2"); rd(A(0, 48), 32'h0, "R2"); rd(A(0, 64), 32'h0, "R2");
        wr(A(0, 128), 32'h5555_5555, "R2"); rd(A(0, 128), 32'hFFFF_FFFF, "R2");
        rd(A(0, 129), 32'h0, "R2");

        // R7 accumulator halves
        wr(A(5, 1), 32'hAAAA_0001, "R7"); wr(A(5, 2), 32'h5555_0002, "R7");
        rd(A(5, 1), 0, "R7"); rd(A(5, 2), 0, "R7");
        wr(A(5, 1), 32'h1234_5678, "R7"); rd(A(5, 2), 0, "R7"); rd(A(5, 1), 0, "R7");

        // R6 shadow banks
        wr(A(0, 1024), 32'h0B00_0000, "R6");
        wr(A(0, 1024 + 3 * 32 + 7), 32'h0B03_0007, "R6");
        wr(A(0, 1024 + 15 * 32 + 31), 32'h0B0F_001F, "R6");
        rd(A(0, 1024 + 3 * 32 + 7), 0, "R6"); rd(A(0, 1024), 0, "R6");
        rd(A(0, 1535), 0, "R6"); rd(A(0, 1025), 32'h77, "R6");

        // R8 way-0 TLB entries, two tables
        wr(A(1, 512), 32'hD000_0001, "R8"); wr(A(1, 640 + 127), 32'hD7F0_0000, "R8");
        wr(A(2, 512), 32'h1000_0001, "R8"); wr(A(2, 640 + 5), 32'h1050_0000, "R8");
        rd(A(1, 512), 0, "R8"); rd(A(2, 512), 0, "R8");
        rd(A(1, 767), 0, "R8"); rd(A(2, 645), 0, "R8"); rd(A(1, 645), 32'h9, "R8");

        // R9 ignored ways and unmapped reads
        wr(A(1, 800), 32'hFFFF_FFFF, "R9"); rd(A(1, 800), 32'hCAFE_0001, "R9");
        wr(A(2, 1535), 32'hFFFF_FFFF, "R9"); rd(A(2, 1535), 32'hCAFE_0002, "R9");
        rd(A(3, 0), 32'hDEAD_BEEF, "R9"); rd(A(0, 1536), 32'h0000_ABCD, "R9");
        rd(A(1, 512), 0, "R9");

        // R13 read and write in one cycle
        op(1, 1, A(0, 11), 32'h2222_0000, 0, "R13"); rd(A(0, 11), 0, "R13");
        op(1, 1, A(5, 2), 32'h9999_0000, 0, "R13"); rd(A(5, 2), 0, "R13");
        op(1, 1, A(0, 1100), 32'h0000_1100, 0, "R13"); rd(A(0, 1100), 0, "R13");

        // R11 next-PC
        core_pc = 32'h0000_0400;
        wr(A(0, 16), 32'h0000_0400, "R11"); wr(A(0, 16), 32'h0000_0800, "R11");
        rd(A(0, 16), 0, "R11");

        // R5 R3 R4 user mode
        wr(A(0, 17), 32'h0000_0000, "R5");
        wr(A(0, 20), 32'h0000_0F0F, "R3"); rd(A(0, 20), 0, "R3");
        wr(A(0, 11), 32'h3333_3333, "R4"); rd(A(0, 11), 32'h4444_0000, "R4");
        wr(A(8, 0), 32'h0000_0030, "R4"); wr(A(0, 16), 32'h0000_1000, "R4");
        wr(A(0, 1024), 32'hBAD0_0000, "R4"); wr(A(0, 17), 32'h0000_0001, "R4");
        rd(A(0, 1024), 32'h0000_5A5A, "R4");

        // R10 R12 low-power requests
        do_reset();
        rd(A(0, 11), 0, "R10"); rd(A(0, 1024 + 3 * 32 + 7), 0, "R10");
        core_pc = 32'h0000_2000;
        wr(A(8, 0), 32'h0000_0001, "R12"); rd(A(8, 0), 0, "R12");
        wr(A(8, 0), 32'h0000_0010, "R12");
        repeat (3) rd(A(8, 0), 0, "R12");
        do_reset();
        core_pc = 32'h0000_3FFC;
        wr(A(8, 0), 32'h0000_0020, "R12"); rd(A(0, 17), 0, "R12");

        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++; checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule